// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low Power Idle Controller

This block decides when the transmit side of a MAC may put the link into Low Power Idle (LPI) and when it must come back out. Two programmable times gate the sequence. The first is a link-stable time, counted in 1 kHz ticks: software must report the link as good for that long without a break before LPI may start. The second is a wake time, counted in 1 MHz ticks: after LPI signalling stops, the transmitter is held off for that long before it may send data again.

Software controls the block through two 32-bit words, selected by a one-bit address. The control/status word holds three control bits (enable, link good and automatic mode), two live state bits, and four event flags. The event flags record transmit LPI entry, transmit LPI exit, receive LPI entry and receive LPI exit. Reading the control/status word clears all four flags, and the interrupt stays high while any flag is set. The timer word holds the wake time and the link-stable time.

The controller has two modes. In manual mode the enable bit requests LPI and the block stays in LPI until software clears the bit. In automatic mode the block enters LPI whenever the transmit path is idle and leaves it as soon as data is pending. The block moves no data, so every pin is a plain level or strobe and none uses a handshake.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: Writing address 1 stores the wake time from bits 15:0 and the link-stable time from bits 26:16. Reading address 1 returns those two fields with bits 31:27 as zero. After reset the timer word reads 0x03E8001E, which is a link-stable time of 1000 and a wake time of 30.
- R2: LPI (`lpi_tx_o` high) is entered only after the link-good bit (bit 17 of word 0) has stayed at 1 for at least the link-stable number of `tick_ms_i` pulses. Clearing the link-good bit restarts that count from zero.
- R3: When `lpi_tx_o` falls, `tx_hold_o` stays high until the wake-time number of `tick_us_i` pulses have been seen, and then drops within two cycles.
- R4: In manual mode (enable, bit 16, set to 1 and automatic, bit 18, set to 0), LPI is entered once the link is stable and `tx_idle_i` is high. LPI is kept when `tx_idle_i` later drops. Clearing the enable bit forces an exit from LPI in the next cycle.
- R5: In automatic mode (bits 16 and 18 both set to 1), LPI is entered when the link is stable and `tx_idle_i` is high, and is left in the cycle after `tx_idle_i` goes low.
- R6: Word 0 bits 3:0 are event flags. Bit 0 is transmit entry (`lpi_tx_o` rising). Bit 1 is transmit exit (`lpi_tx_o` falling). Bit 2 is receive entry (`rx_lpi_i` rising). Bit 3 is receive exit (`rx_lpi_i` falling). Each flag is set at the clock edge that registers its event. A read of word 0 returns the flags and clears all four.
- R7: `irq_o` is high exactly while at least one event flag is set.
- R8: If a read of word 0 falls in the same cycle as a new event, the flag for that event is set after the read. All older flags are cleared.
- R9: Clearing the link-good bit while in LPI makes the block leave LPI in the next cycle and sets the transmit-exit flag. LPI is re-entered only after a fresh link-stable count.
- R10: Reading word 0 returns enable in bit 16, link good in bit 17 and automatic in bit 18. It returns the transmit LPI state in bit 8 and the registered receive LPI state in bit 9. All other bits not defined above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read of word 0 clears the flags) |
| reg_addr_i | input | 1 | Word select: 0 for control/status, 1 for timer |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word (combinational) |
| tx_idle_i | input | 1 | Transmit path has no data pending |
| rx_lpi_i | input | 1 | Receive path reports LPI from the PHY |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| lpi_tx_o | output | 1 | Transmit LPI request to the PHY signalling |
| tx_hold_o | output | 1 | Transmitter must not send (in LPI or wake time) |
| irq_o | output | 1 | LPI event interrupt |

## Verification
The link-stable gate is tested three ways: with one tick too few, with a count broken by a link drop and then restarted, and with the exact count. Together these separate a counter that never resets from one that compares with the wrong limit. The controller is taken out of LPI in three ways: by clearing enable, by pending data in automatic mode, and by a link drop. A pending-data pattern in manual mode shows that the two modes differ. The wake hold is checked one tick short of the wake time and after it. The event flags are checked both for a plain read-clear and for a read in the same cycle as a receive exit, which shows whether a new event survives the clear.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LPI  = 2'd1,
    ST_WAKE = 2'd2
  } lpi_state_e;

  // control/status word layout
  localparam int unsigned CS_EN_BIT   = 16;
  localparam int unsigned CS_LINK_BIT = 17;
  localparam int unsigned CS_AUTO_BIT = 18;
  localparam int unsigned CS_TXST_BIT = 8;
  localparam int unsigned CS_RXST_BIT = 9;

  // event flag indices
  localparam int unsigned EV_TX_ENTER = 0;
  localparam int unsigned EV_TX_EXIT  = 1;
  localparam int unsigned EV_RX_ENTER = 2;
  localparam int unsigned EV_RX_EXIT  = 3;
  localparam int unsigned EV_COUNT    = 4;

endpackage

// File: rtl/lpi_link_qual.sv
module lpi_link_qual #(
  parameter int unsigned LS_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            link_good_i,
  input  logic            tick_ms_i,
  input  logic [LS_W-1:0] ls_time_i,
  output logic            stable_o
);

  logic [LS_W-1:0] good_cnt_q;

  // counts millisecond ticks while the link stays good, saturating at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_cnt_q <= '0;
    end else if (!link_good_i) begin
      good_cnt_q <= '0;
    end else if (tick_ms_i && (good_cnt_q < ls_time_i)) begin
      good_cnt_q <= good_cnt_q + 1'b1;
    end
  end

  assign stable_o = link_good_i && (good_cnt_q >= ls_time_i);

  AST_DROP_CLEARS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_good_i && ls_time_i != '0) |=> (!stable_o || ls_time_i == '0)); // R2

endmodule

// File: rtl/lpi_tx_seq.sv
module lpi_tx_seq
  import eee_lpi_pkg::*;
#(
  parameter int unsigned TW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            auto_i,
  input  logic            link_good_i,
  input  logic            link_stable_i,
  input  logic            tx_idle_i,
  input  logic            tick_us_i,
  input  logic [TW_W-1:0] wake_time_i,
  output logic            lpi_tx_o,
  output logic            tx_hold_o,
  output logic            enter_o,
  output logic            exit_o
);

  lpi_state_e      state_q, state_d;
  logic [TW_W-1:0] wake_cnt_q;
  logic            wake_done;
  logic            leave_req;

  assign wake_done = (wake_cnt_q >= wake_time_i);
  assign leave_req = !en_i || !link_good_i || (auto_i && !tx_idle_i);

  always_comb begin
    state_d = state_q;
    enter_o = 1'b0;
    exit_o  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (en_i && link_stable_i && tx_idle_i) begin
          state_d = ST_LPI;
          enter_o = 1'b1;
        end
      end
      ST_LPI: begin
        if (leave_req) begin
          state_d = ST_WAKE;
          exit_o  = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wake_done) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  // wake timer: restarts on exit, counts microsecond ticks while waking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_cnt_q <= '0;
    end else if (exit_o) begin
      wake_cnt_q <= '0;
    end else if (state_q == ST_WAKE && tick_us_i && !wake_done) begin
      wake_cnt_q <= wake_cnt_q + 1'b1;
    end
  end

  assign lpi_tx_o  = (state_q == ST_LPI);
  assign tx_hold_o = (state_q != ST_RUN);

  AST_ENTRY_NEEDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lpi_tx_o) |-> $past(link_stable_i)); // R2
  AST_HOLD_AFTER_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lpi_tx_o) |-> tx_hold_o); // R3
  AST_DISABLE_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpi_tx_o && !en_i) |=> !lpi_tx_o); // R4
  AST_AUTO_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpi_tx_o && auto_i && !tx_idle_i) |=> !lpi_tx_o); // R5
  AST_LINK_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpi_tx_o && !link_good_i) |=> !lpi_tx_o); // R9

endmodule

// File: rtl/lpi_status.sv
module lpi_status
  import eee_lpi_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_enter_i,
  input  logic                tx_exit_i,
  input  logic                rx_lpi_i,
  input  logic                clr_i,
  output logic [EV_COUNT-1:0] flags_o,
  output logic                rx_state_o,
  output logic                irq_o
);

  logic                rx_q;
  logic [EV_COUNT-1:0] ev;
  logic [EV_COUNT-1:0] flags_q;

  always_comb begin
    ev              = '0;
    ev[EV_TX_ENTER] = tx_enter_i;
    ev[EV_TX_EXIT]  = tx_exit_i;
    ev[EV_RX_ENTER] = rx_lpi_i && !rx_q;
    ev[EV_RX_EXIT]  = !rx_lpi_i && rx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      rx_q    <= rx_lpi_i;
      flags_q <= (clr_i ? '0 : flags_q) | ev;
    end
  end

  assign flags_o    = flags_q;
  assign rx_state_o = rx_q;
  assign irq_o      = |flags_q;

  AST_ENTRY_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_enter_i |=> irq_o); // R7
  AST_EVENT_SURVIVES_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && tx_exit_i) |=> flags_o[EV_TX_EXIT]); // R8
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tx_enter_i && !tx_exit_i && (rx_lpi_i == rx_q)) |=> (flags_o == '0)); // R6

endmodule

// File: rtl/lpi_regs.sv
module lpi_regs
  import eee_lpi_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TW_W   = 16,
  parameter int unsigned LS_W   = 11,
  parameter int unsigned LS_LSB = 16,
  parameter logic [TW_W-1:0] RST_TW = 16'd30,
  parameter logic [LS_W-1:0] RST_LS = 11'd1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic                addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [EV_COUNT-1:0] flags_i,
  input  logic                tx_state_i,
  input  logic                rx_state_i,
  output logic                en_o,
  output logic                link_good_o,
  output logic                auto_o,
  output logic [TW_W-1:0]     wake_time_o,
  output logic [LS_W-1:0]     ls_time_o,
  output logic                clr_flags_o
);

  localparam int unsigned LS_MSB = LS_LSB + LS_W - 1;

  logic wr_ctrl, wr_tmr;
  assign wr_ctrl = wr_i && !addr_i;
  assign wr_tmr  = wr_i &&  addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      link_good_o <= 1'b0;
      auto_o      <= 1'b0;
    end else if (wr_ctrl) begin
      en_o        <= wdata_i[CS_EN_BIT];
      link_good_o <= wdata_i[CS_LINK_BIT];
      auto_o      <= wdata_i[CS_AUTO_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_time_o <= RST_TW;
      ls_time_o   <= RST_LS;
    end else if (wr_tmr) begin
      wake_time_o <= wdata_i[TW_W-1:0];
      ls_time_o   <= wdata_i[LS_MSB:LS_LSB];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i) begin
      rdata_o[TW_W-1:0]      = wake_time_o;
      rdata_o[LS_MSB:LS_LSB] = ls_time_o;
    end else begin
      rdata_o[EV_COUNT-1:0]  = flags_i;
      rdata_o[CS_TXST_BIT]   = tx_state_i;
      rdata_o[CS_RXST_BIT]   = rx_state_i;
      rdata_o[CS_EN_BIT]     = en_o;
      rdata_o[CS_LINK_BIT]   = link_good_o;
      rdata_o[CS_AUTO_BIT]   = auto_o;
    end
  end

  assign clr_flags_o = rd_i && !addr_i;

  AST_TIMER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tmr |=> (wake_time_o == $past(wdata_i[TW_W-1:0]))); // R1

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TW_W   = 16,
  parameter int unsigned LS_W   = 11,
  parameter int unsigned LS_LSB = 16,
  parameter logic [TW_W-1:0] RST_TW = 16'd30,
  parameter logic [LS_W-1:0] RST_LS = 11'd1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tx_idle_i,
  input  logic              rx_lpi_i,
  input  logic              tick_us_i,
  input  logic              tick_ms_i,
  output logic              lpi_tx_o,
  output logic              tx_hold_o,
  output logic              irq_o
);

  logic                en, link_good, auto_mode, link_stable;
  logic [TW_W-1:0]     wake_time;
  logic [LS_W-1:0]     ls_time;
  logic                clr_flags, tx_enter, tx_exit, rx_state;
  logic [EV_COUNT-1:0] flags;

  lpi_regs #(
    .DATA_W(DATA_W), .TW_W(TW_W), .LS_W(LS_W), .LS_LSB(LS_LSB),
    .RST_TW(RST_TW), .RST_LS(RST_LS)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .flags_i     (flags),
    .tx_state_i  (lpi_tx_o),
    .rx_state_i  (rx_state),
    .en_o        (en),
    .link_good_o (link_good),
    .auto_o      (auto_mode),
    .wake_time_o (wake_time),
    .ls_time_o   (ls_time),
    .clr_flags_o (clr_flags)
  );

  lpi_link_qual #(.LS_W(LS_W)) i_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_good_i (link_good),
    .tick_ms_i   (tick_ms_i),
    .ls_time_i   (ls_time),
    .stable_o    (link_stable)
  );

  lpi_tx_seq #(.TW_W(TW_W)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en),
    .auto_i        (auto_mode),
    .link_good_i   (link_good),
    .link_stable_i (link_stable),
    .tx_idle_i     (tx_idle_i),
    .tick_us_i     (tick_us_i),
    .wake_time_i   (wake_time),
    .lpi_tx_o      (lpi_tx_o),
    .tx_hold_o     (tx_hold_o),
    .enter_o       (tx_enter),
    .exit_o        (tx_exit)
  );

  lpi_status i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_enter_i (tx_enter),
    .tx_exit_i  (tx_exit),
    .rx_lpi_i   (rx_lpi_i),
    .clr_i      (clr_flags),
    .flags_o    (flags),
    .rx_state_o (rx_state),
    .irq_o      (irq_o)
  );

endmodule

// File: tb/test_eee_lpi_ctrl.sv
module test_eee_lpi_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_idle = 1'b0, rx_lpi = 1'b0, tick_us = 1'b0, tick_ms = 1'b0;
  logic        lpi_tx, tx_hold, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] EN   = 32'h0001_0000;
  localparam logic [31:0] LINK = 32'h0002_0000;
  localparam logic [31:0] AUTO = 32'h0004_0000;

  always #4 clk = ~clk;

  eee_lpi_ctrl i_eee_lpi_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_idle_i(tx_idle), .rx_lpi_i(rx_lpi),
    .tick_us_i(tick_us), .tick_ms_i(tick_ms),
    .lpi_tx_o(lpi_tx), .tx_hold_o(tx_hold), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic ms_pulse();
    @(negedge clk); tick_ms = 1'b1;
    @(negedge clk); tick_ms = 1'b0;
  endtask

  task automatic us_pulse();
    @(negedge clk); tick_us = 1'b1;
    @(negedge clk); tick_us = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    cyc(1);
    check("R3 hold after reset", {31'b0, tx_hold}, 32'd0);
    check("R7 irq after reset", {31'b0, irq}, 32'd0);
    check("R2 lpi after reset", {31'b0, lpi_tx}, 32'd0);
    reg_read(1'b1, v); check("R1 timer reset value", v, 32'h03E8_001E);
    reg_read(1'b0, v); check("R10 ctrl reset value", v, 32'h0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    reg_write(1'b1, 32'hFFFF_FFFF);
    reg_read(1'b1, v); check("R1 timer fields only", v, 32'h07FF_FFFF);
    reg_write(1'b1, 32'h0003_0004);   // link-stable 3, wake 4
    reg_read(1'b1, v); check("R1 timer readback", v, 32'h0003_0004);
  endtask

  task automatic t_manual();
    logic [31:0] v;
    tx_idle = 1'b1;
    reg_write(1'b0, EN | LINK);
    reg_read(1'b0, v); check("R10 control bits", v, 32'h0003_0000);
    ms_pulse(); ms_pulse(); cyc(3);
    check("R2 too few ticks", {31'b0, lpi_tx}, 32'd0);
    reg_write(1'b0, EN);
    reg_write(1'b0, EN | LINK);
    ms_pulse(); ms_pulse(); cyc(3);
    check("R2 count restarted", {31'b0, lpi_tx}, 32'd0);
    ms_pulse(); cyc(3);
    check("R2 enter after stable", {31'b0, lpi_tx}, 32'd1);
    check("R3 hold in LPI", {31'b0, tx_hold}, 32'd1);
    check("R7 irq on entry", {31'b0, irq}, 32'd1);
    reg_read(1'b0, v); check("R6 entry flag and state", v, 32'h0003_0101);
    cyc(1);
    check("R7 irq cleared by read", {31'b0, irq}, 32'd0);
    tx_idle = 1'b0; cyc(3);
    check("R4 manual keeps LPI with data", {31'b0, lpi_tx}, 32'd1);
    reg_write(1'b0, LINK);
    cyc(1);
    check("R4 disable forces exit", {31'b0, lpi_tx}, 32'd0);
    check("R3 hold during wake", {31'b0, tx_hold}, 32'd1);
    us_pulse(); us_pulse(); us_pulse(); cyc(3);
    check("R3 hold one tick short", {31'b0, tx_hold}, 32'd1);
    us_pulse(); cyc(2);
    check("R3 hold released", {31'b0, tx_hold}, 32'd0);
    reg_read(1'b0, v); check("R6 exit flag", v, 32'h0002_0002);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    @(negedge clk); rx_lpi = 1'b1;
    @(negedge clk);
    check("R7 irq on rx entry", {31'b0, irq}, 32'd1);
    reg_read(1'b0, v); check("R6 rx entry flag", v, 32'h0002_0204);
    check("R7 irq low after read", {31'b0, irq}, 32'd0);
    @(negedge clk);
    rx_lpi = 1'b0; rd = 1'b1; addr = 1'b0;
    #1 v = rdata;
    check("R6 read before rx exit", v, 32'h0002_0200);
    @(negedge clk); rd = 1'b0;
    reg_read(1'b0, v); check("R8 event kept across read", v, 32'h0002_0008);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    reg_write(1'b1, 32'h0003_0000);   // wake time 0
    tx_idle = 1'b0;
    reg_write(1'b0, EN | LINK | AUTO);
    cyc(3);
    check("R5 no entry with data pending", {31'b0, lpi_tx}, 32'd0);
    tx_idle = 1'b1; cyc(3);
    check("R5 auto entry", {31'b0, lpi_tx}, 32'd1);
    tx_idle = 1'b0; cyc(3);
    check("R5 auto exit", {31'b0, lpi_tx}, 32'd0);
    check("R3 zero wake time", {31'b0, tx_hold}, 32'd0);
    reg_read(1'b0, v); check("R6 auto flags", v, 32'h0007_0003);
  endtask

  task automatic t_linkdrop();
    logic [31:0] v;
    tx_idle = 1'b1; cyc(3);
    check("R9 in LPI before drop", {31'b0, lpi_tx}, 32'd1);
    reg_write(1'b0, EN | AUTO);
    cyc(1);
    check("R9 abort on link drop", {31'b0, lpi_tx}, 32'd0);
    reg_read(1'b0, v); check("R9 exit flag on drop", v, 32'h0005_0003);
    reg_write(1'b0, EN | LINK | AUTO);
    ms_pulse(); ms_pulse(); cyc(3);
    check("R9 stable count restarted", {31'b0, lpi_tx}, 32'd0);
    ms_pulse(); cyc(3);
    check("R9 re-entry after count", {31'b0, lpi_tx}, 32'd1);
    check("R7 irq after re-entry", {31'b0, irq}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timer();
    t_manual();
    t_rx();
    t_auto();
    t_linkdrop();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule